// File: doc/BRIEF.md
# Multi-Master Shared-Bus Arbiter with Split Parking

This block decides which of up to sixteen bus masters drives the address and control phase of a shared pipelined bus. Each master raises a request line and may raise a lock line. The arbiter answers with a one-hot grant vector. Grant priority is fixed: lower index wins. Master 0 is the default owner whenever nobody eligible is asking.

Ownership only moves at the end of a transfer, which is a clock edge where the bus ready input is high. On every such edge, two registered outputs load the identity and lock state of the master that held the grant just before the edge: the owner number and the locked-sequence flag. Both outputs therefore line up with the address phase, not with the grant.

A slave can answer a transfer with a SPLIT response. The master whose transfer was in the data phase is then parked: it is masked out of arbitration. It stays masked until the slave raises that master's bit on the resume vector.

Top module: `mbus_arbiter`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) the grant is master 0 only, the owner number is 0, the lock flag is 0 and no master is parked; at all times exactly one grant bit is set.
- R2: At a ready edge with no lock hold, the new grant goes to the lowest-index master whose request is high and which is not parked.
- R3: When no unparked master requests at a ready edge, master 0 receives the grant.
- R4: At an edge where `hready_i` is low, the grant does not change.
- R5: At each ready edge, `owner_id_o` loads the index of the master that held the grant before that edge; at other edges it holds its value.
- R6: `owner_lock_o` loads, at the same edges as R5, the lock input of that same master.
- R7: While the granted master holds its lock input high and is not being parked, the grant stays with it at ready edges, even when a higher-priority master requests.
- R8: Responses are encoded OKAY=00, ERROR=01, RETRY=10, SPLIT=11, and transfer types IDLE=00, BUSY=01, NONSEQ=10, SEQ=11. A SPLIT response at a ready edge parks the master in the data phase if its transfer was NONSEQ or SEQ. That master loses eligibility at that same edge.
- R9: A parked master other than master 0 is never granted. Its resume bit being high at an edge unparks it, and it competes in that same edge's arbitration. A park and a resume for the same master at one edge leave it parked.
- R10: OKAY, ERROR and RETRY responses park nobody. A SPLIT response whose data-phase transfer was IDLE or BUSY parks nobody.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N | Per-master bus request |
| lock_i | input | N | Per-master locked-access request |
| hready_i | input | 1 | High when the current transfer completes this cycle |
| htrans_i | input | 2 | Transfer type of the current address phase |
| hresp_i | input | 2 | Slave response of the current data phase |
| resume_i | input | N | Per-master split resume bits from the slaves |
| grant_o | output | N | One-hot grant |
| owner_id_o | output | ID_W | Index of the address-phase owner |
| owner_lock_o | output | 1 | Address-phase owner is in a locked sequence |

## Verification
The first test sweeps all request patterns on a four-master build with ready held high. This separates a correct lowest-index pick from a wrong priority direction and from a missing default. Each new grant is compared with the owner number one edge later, which confirms the address-phase lag.

A run of not-ready cycles with a pending higher request shows whether a handover slips out early. In the locked run, master 2 keeps the grant while master 0 requests, and the lock flag is checked as it rises and falls.

The split run parks master 1 and keeps it parked across idle cycles. A single resume pulse must restore the grant in the same edge. After that, ERROR and RETRY responses, and a SPLIT arriving behind an IDLE transfer, must leave the grant in place.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // slave response codes
  localparam logic [1:0] RSP_OKAY  = 2'b00;
  localparam logic [1:0] RSP_ERROR = 2'b01;
  localparam logic [1:0] RSP_RETRY = 2'b10;
  localparam logic [1:0] RSP_SPLIT = 2'b11;
  // transfer type codes
  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0] elig,
  output logic [N-1:0] pick
);
  localparam logic [N-1:0] DFLT = N'(1);

  logic [N-1:0] below;   // below[i]: some lower index is eligible
  logic [N-1:0] first;

  assign below[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign below[i] = below[i-1] | elig[i-1];
  end

  assign first = elig & ~below;
  assign pick  = (|elig) ? first : DFLT;
endmodule

// File: rtl/arb_onehot_enc.sv
module arb_onehot_enc #(
  parameter int N    = 16,
  parameter int ID_W = 4
) (
  input  logic [N-1:0]    onehot,
  output logic [ID_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = idx | ID_W'(i);
    end
  end
endmodule

// File: rtl/arb_split_mask.sv
module arb_split_mask #(
  parameter int N    = 16,
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            park_en,
  input  logic [ID_W-1:0] park_id,
  input  logic [N-1:0]    resume,
  output logic [N-1:0]    mask_q,
  output logic [N-1:0]    mask_nx
);
  logic [N-1:0] park_vec;

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign park_vec[i] = park_en && (park_id == ID_W'(i));
  end

  // a new park outranks a resume arriving in the same cycle
  assign mask_nx = (mask_q & ~resume) | park_vec;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_nx;
  end
endmodule

// File: rtl/mbus_arbiter.sv
module mbus_arbiter
  import arb_pkg::*;
#(
  parameter int N    = 16,
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req_i,
  input  logic [N-1:0]    lock_i,
  input  logic            hready_i,
  input  logic [1:0]      htrans_i,
  input  logic [1:0]      hresp_i,
  input  logic [N-1:0]    resume_i,
  output logic [N-1:0]    grant_o,
  output logic [ID_W-1:0] owner_id_o,
  output logic            owner_lock_o
);
  localparam logic [N-1:0] DFLT = N'(1);

  logic [N-1:0]    grant_q, grant_nx, elig, pick;
  logic [N-1:0]    park_q, park_nx;
  logic [ID_W-1:0] grant_idx, addr_id_q, data_id_q;
  logic            data_act_q, lock_q, split_hit, hold, addr_act;

  assign addr_act  = (htrans_i == TR_NONSEQ) || (htrans_i == TR_SEQ);
  assign split_hit = hready_i && data_act_q && (hresp_i == RSP_SPLIT);

  arb_split_mask #(.N(N), .ID_W(ID_W)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .park_en (split_hit),
    .park_id (data_id_q),
    .resume  (resume_i),
    .mask_q  (park_q),
    .mask_nx (park_nx)
  );

  assign elig = req_i & ~park_nx;

  arb_prio_pick #(.N(N)) u_pick (
    .elig (elig),
    .pick (pick)
  );

  arb_onehot_enc #(.N(N), .ID_W(ID_W)) u_enc (
    .onehot (grant_q),
    .idx    (grant_idx)
  );

  assign hold     = |(grant_q & lock_i & ~park_nx);
  assign grant_nx = hold ? grant_q : pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q    <= DFLT;
      addr_id_q  <= '0;
      data_id_q  <= '0;
      data_act_q <= 1'b0;
      lock_q     <= 1'b0;
    end else if (hready_i) begin
      grant_q    <= grant_nx;
      addr_id_q  <= grant_idx;
      lock_q     <= |(grant_q & lock_i);
      data_id_q  <= addr_id_q;
      data_act_q <= addr_act;
    end
  end

  assign grant_o      = grant_q;
  assign owner_id_o   = addr_id_q;
  assign owner_lock_o = lock_q;
endmodule

// File: rtl/mbus_arbiter_chk.sv
module mbus_arbiter_chk
  import arb_pkg::*;
#(
  parameter int N    = 16,
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [N-1:0]    lock_i,
  input logic            hready_i,
  input logic [1:0]      hresp_i,
  input logic [N-1:0]    grant_o,
  input logic [ID_W-1:0] owner_id_o,
  input logic            owner_lock_o,
  input logic [N-1:0]    park_q
);
  logic [ID_W-1:0] g_idx;
  always_comb begin
    g_idx = '0;
    for (int i = 0; i < N; i++) if (grant_o[i]) g_idx = g_idx | ID_W'(i);
  end

  a_r1_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot(grant_o));

  a_r4_no_handover: assert property (@(posedge clk) disable iff (rst)
    !hready_i |=> $stable(grant_o));

  a_r5_owner_stable: assert property (@(posedge clk) disable iff (rst)
    !hready_i |=> ($stable(owner_id_o) && $stable(owner_lock_o)));

  a_r5_owner_follows: assert property (@(posedge clk) disable iff (rst)
    hready_i |=> (owner_id_o == $past(g_idx)));

  a_r7_lock_keeps: assert property (@(posedge clk) disable iff (rst)
    (hready_i && (hresp_i != RSP_SPLIT) && |(grant_o & lock_i & ~park_q))
    |=> $stable(grant_o));

  for (genvar i = 1; i < N; i++) begin : g_park
    a_r9_parked_no_grant: assert property (@(posedge clk) disable iff (rst)
      park_q[i] |-> !grant_o[i]);
  end
endmodule

bind mbus_arbiter mbus_arbiter_chk #(.N(N), .ID_W(ID_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .lock_i       (lock_i),
  .hready_i     (hready_i),
  .hresp_i      (hresp_i),
  .grant_o      (grant_o),
  .owner_id_o   (owner_id_o),
  .owner_lock_o (owner_lock_o),
  .park_q       (park_q)
);

// File: tb/mbus_arbiter_tb.sv
module mbus_arbiter_tb;
  localparam int N  = 4;
  localparam int IW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic [N-1:0]  req, lock, resume;
  logic          hready;
  logic [1:0]    htrans, hresp;
  logic [N-1:0]  grant;
  logic [IW-1:0] owner_id;
  logic          owner_lock;

  int checks = 0;
  int fails  = 0;

  mbus_arbiter #(.N(N), .ID_W(IW)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .req_i        (req),
    .lock_i       (lock),
    .hready_i     (hready),
    .htrans_i     (htrans),
    .hresp_i      (hresp),
    .resume_i     (resume),
    .grant_o      (grant),
    .owner_id_o   (owner_id),
    .owner_lock_o (owner_lock)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [N-1:0] best(input logic [N-1:0] r);
    logic [N-1:0] res = '0;
    for (int i = N - 1; i >= 0; i--) if (r[i]) res = N'(1) << i;
    if (res == '0) res = N'(1);
    return res;
  endfunction

  function automatic int idx_of(input logic [N-1:0] oh);
    int k = 0;
    for (int i = 0; i < N; i++) if (oh[i]) k = i;
    return k;
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0]  prev;
    logic [IW-1:0] held_id;
    rst = 1'b1; req = '0; lock = '0; resume = '0;
    hready = 1'b1; htrans = 2'b10; hresp = 2'b00;
    repeat (3) step();
    chk("R1 reset grant", 32'(grant), 32'h1);
    chk("R1 reset owner", 32'(owner_id), 32'h0);
    chk("R1 reset lock flag", 32'(owner_lock), 32'h0);
    rst = 1'b0;

    // R2 R3 R5: sweep every request pattern
    prev = N'(1);
    for (int r = 0; r < (1 << N); r++) begin
      req = N'(r);
      step();
      chk("R2/R3 sweep grant", 32'(grant), 32'(best(N'(r))));
      chk("R5 sweep owner", 32'(owner_id), 32'(idx_of(prev)));
      chk("R6 lock flag low", 32'(owner_lock), 32'h0);
      prev = best(N'(r));
    end

    // R4: no handover while not ready
    req = 4'b0010; hready = 1'b0;
    held_id = owner_id;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R4 grant held", 32'(grant), 32'h1);
      chk("R5 owner held", 32'(owner_id), 32'(held_id));
    end
    hready = 1'b1;
    step();
    chk("R4 handover on ready", 32'(grant), 32'h2);
    chk("R5 owner lag", 32'(owner_id), 32'h0);
    step();
    chk("R5 owner follows", 32'(owner_id), 32'h1);

    // R7 R6: locked master keeps the bus
    req = 4'b0100; lock = 4'b0100;
    step();
    chk("R7 locked master granted", 32'(grant), 32'h4);
    req = 4'b0101;
    step();
    chk("R7 lock hold", 32'(grant), 32'h4);
    chk("R6 lock flag high", 32'(owner_lock), 32'h1);
    chk("R5 owner is 2", 32'(owner_id), 32'h2);
    step();
    chk("R7 lock hold again", 32'(grant), 32'h4);
    lock = '0;
    step();
    chk("R7 release", 32'(grant), 32'h1);
    chk("R6 lock flag falls", 32'(owner_lock), 32'h0);

    // R8 R9: split parks master 1
    req = 4'b0010;
    step();
    chk("R2 master 1 granted", 32'(grant), 32'h2);
    step();
    step();
    hresp = 2'b11;
    step();
    chk("R8 split parks master", 32'(grant), 32'h1);
    hresp = 2'b00;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R9 parked not granted", 32'(grant), 32'h1);
    end
    resume = 4'b0010;
    step();
    chk("R9 resume restores", 32'(grant), 32'h2);
    resume = '0;
    step();
    step();

    // R10: non-split responses and split behind idle
    hresp = 2'b01;
    step();
    chk("R10 error no park", 32'(grant), 32'h2);
    hresp = 2'b10;
    step();
    chk("R10 retry no park", 32'(grant), 32'h2);
    hresp = 2'b00; htrans = 2'b00;
    step();
    step();
    hresp = 2'b11;
    step();
    chk("R10 split after idle", 32'(grant), 32'h2);
    hresp = 2'b00;
    step();
    chk("R10 still granted", 32'(grant), 32'h2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule